// File: doc/BRIEF.md
# Port Pad Mode and Alternate-Function Multiplexer

This block sits between the configuration state of a 16-pin port and the pads themselves. Each pin carries a 2-bit mode code, an output-type bit, a 2-bit pull code and a 4-bit channel selector. From these the block derives, every cycle and without registers, the pad output enable, the pad output level, the weak pull-up and pull-down enables and the input buffer enable. The output level comes either from the port's output data value or from one of eight peripheral channels. The pin's selector chooses the channel.

The return path is registered. Every pad input passes through a first capture flop and then into the input data register, so a pad change appears there two clock edges later. The registered value is then routed to the one peripheral input channel named by the same selector that drives the output side. The first flop is a first synchronizer stage, and the input data register is the second. Analog pins read as 0 in the input data register. Analog pins never drive their pad, never enable a pull and keep their input buffer off.

Top module: `pad_port_mux`

## Requirements
- R1: Mode code 00 (input) gives output enable 0. Mode code 01 with type bit 0 (push-pull) gives output enable 1 and an output level equal to the pin's output data bit. The output level is 0 whenever the output enable is 0.
- R2: With type bit 1 (open-drain) in mode 01 or 10, a source level of 0 gives output enable 1 with output level 0. A source level of 1 gives output enable 0. The output level is always 0 in this type.
- R3: Pull code 01 enables only the pull-up. Pull code 10 enables only the pull-down. Codes 00 and 11 enable neither.
- R4: Mode code 11 (analog) gives output enable 0, input buffer enable 0, and both pull enables 0, whatever the pull code and type bit.
- R5: The input buffer enable is 1 in modes 00, 01 and 10.
- R6: In mode 10 (alternate function) with selector value k from 0 to 7, the pin's source level and source enable are bit p of channel k's output and enable vectors. These vectors are indexed k*16+p. With push-pull type, the output enable equals the channel's enable and the output level equals the channel level ANDed with that enable.
- R7: In mode 10, a selector value from 8 to 15 gives output enable 0 and output level 0.
- R8: Peripheral input bit k*16+p equals input data bit p when pin p's selector equals k, and 0 otherwise. A selector from 8 to 15 feeds no channel.
- R9: The input data register takes every pad value two clock edges after it is presented, on every cycle.
- R10: A pin in analog mode at a clock edge reads 0 in the input data register after that edge.
- R11: After reset the input data register and all peripheral input bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 32 | Mode code, pin p at bits 2p+1:2p |
| otype_i | input | 16 | Output type, 1 = open-drain |
| pull_i | input | 32 | Pull code, pin p at bits 2p+1:2p |
| af_sel_i | input | 64 | Channel selector, pin p at bits 4p+3:4p |
| gp_out_i | input | 16 | Output data value per pin |
| af_out_i | input | 128 | Peripheral output levels, channel k pin p at bit k*16+p |
| af_oe_i | input | 128 | Peripheral output enables, same indexing |
| pad_in_i | input | 16 | Pad input levels |
| pad_oe_o | output | 16 | Pad output enable |
| pad_out_o | output | 16 | Pad output level |
| pad_pu_o | output | 16 | Weak pull-up enable |
| pad_pd_o | output | 16 | Weak pull-down enable |
| pad_ie_o | output | 16 | Input buffer enable |
| in_data_o | output | 16 | Input data register |
| af_in_o | output | 128 | Peripheral input bits, channel k pin p at bit k*16+p |

## Verification
Two functions can meet in the same cycle. The first is a mode change into or out of analog. The second is the pipelined sample of a pad value that was presented before the change. Whether that value lands in the input data register or is forced to 0 depends on the mode at the loading edge. The random phase changes modes and pad values together on every cycle. A bench model of the two-edge pipeline, masked by the mode of the loading cycle, judges the input data register and every peripheral input bit. This also checks that a selector change in that same cycle re-routes the registered bit to the new channel at once.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;
  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_GPO = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pin_mode_e;

  localparam logic [1:0] PULL_UP = 2'b01;
  localparam logic [1:0] PULL_DN = 2'b10;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
    logic pd;
    logic ie;
  } pad_ctrl_t;
endpackage

// File: rtl/af_channel_mux.sv
module af_channel_mux #(
  parameter int N_AF  = 8,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_AF-1:0]  ch_out_i,
  input  logic [N_AF-1:0]  ch_oe_i,
  input  logic             in_bit_i,
  output logic             src_out_o,
  output logic             src_oe_o,
  output logic [N_AF-1:0]  ch_in_o
);
  logic [N_AF-1:0] hit;

  for (genvar k = 0; k < N_AF; k++) begin : g_ch
    assign hit[k]     = (int'(sel_i) == k);
    assign ch_in_o[k] = hit[k] & in_bit_i;
  end

  // out-of-range selector leaves hit all zero: no source, no sink
  assign src_out_o = |(hit & ch_out_i);
  assign src_oe_o  = |(hit & ch_oe_i);
endmodule

// File: rtl/pad_ctrl_decode.sv
module pad_ctrl_decode
  import pad_mux_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       od_i,
  input  logic [1:0] pull_i,
  input  logic       gp_out_i,
  input  logic       src_out_i,
  input  logic       src_oe_i,
  output pad_ctrl_t  ctrl_o
);
  pin_mode_e mode;
  logic      lvl;
  logic      drv;

  assign mode = pin_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_GPO: begin lvl = gp_out_i;  drv = 1'b1;     end
      MODE_ALT: begin lvl = src_out_i; drv = src_oe_i; end
      default:  begin lvl = 1'b0;      drv = 1'b0;     end
    endcase
  end

  always_comb begin
    ctrl_o    = '0;
    ctrl_o.ie = (mode != MODE_ANA);
    if (mode != MODE_ANA) begin
      ctrl_o.pu = (pull_i == PULL_UP);
      ctrl_o.pd = (pull_i == PULL_DN);
    end
    if (od_i) begin
      ctrl_o.oe  = drv & ~lvl;
      ctrl_o.out = 1'b0;
    end else begin
      ctrl_o.oe  = drv;
      ctrl_o.out = drv & lvl;
    end
  end
endmodule

// File: rtl/pad_in_sampler.sv
module pad_in_sampler #(
  parameter int N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pad_in_i,
  input  logic [N_PINS-1:0] ana_i,
  output logic [N_PINS-1:0] idr_o
);
  logic [N_PINS-1:0] s1_q;
  logic [N_PINS-1:0] idr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      idr_q <= '0;
    end else begin
      s1_q  <= pad_in_i;
      idr_q <= s1_q & ~ana_i;
    end
  end

  assign idr_o = idr_q;

  // edges seen since reset, saturating, for the latency check window
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_IDR_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (idr_o == ($past(pad_in_i, 2) & ~$past(ana_i)))); // R9

  for (genvar p = 0; p < N_PINS; p++) begin : g_chk
    AST_ANALOG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ana_i[p] |=> !idr_o[p]); // R10
  end
endmodule

// File: rtl/pad_port_mux.sv
module pad_port_mux
  import pad_mux_pkg::*;
#(
  parameter int N_PINS = 16,
  parameter int N_AF   = 8,
  parameter int SEL_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2*N_PINS-1:0]      mode_i,
  input  logic [N_PINS-1:0]        otype_i,
  input  logic [2*N_PINS-1:0]      pull_i,
  input  logic [SEL_W*N_PINS-1:0]  af_sel_i,
  input  logic [N_PINS-1:0]        gp_out_i,
  input  logic [N_AF*N_PINS-1:0]   af_out_i,
  input  logic [N_AF*N_PINS-1:0]   af_oe_i,
  input  logic [N_PINS-1:0]        pad_in_i,
  output logic [N_PINS-1:0]        pad_oe_o,
  output logic [N_PINS-1:0]        pad_out_o,
  output logic [N_PINS-1:0]        pad_pu_o,
  output logic [N_PINS-1:0]        pad_pd_o,
  output logic [N_PINS-1:0]        pad_ie_o,
  output logic [N_PINS-1:0]        in_data_o,
  output logic [N_AF*N_PINS-1:0]   af_in_o
);
  localparam int AF_BITS = N_AF * N_PINS;

  logic [N_PINS-1:0] ana;
  logic [N_PINS-1:0] idr;

  pad_in_sampler #(.N_PINS(N_PINS)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pad_in_i (pad_in_i),
    .ana_i    (ana),
    .idr_o    (idr)
  );

  assign in_data_o = idr;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [N_AF-1:0]  ch_out;
    logic [N_AF-1:0]  ch_oe;
    logic [N_AF-1:0]  ch_in;
    logic [SEL_W-1:0] sel;
    logic [1:0]       mode;
    logic             src_out;
    logic             src_oe;
    pad_ctrl_t        ctrl;

    assign sel  = af_sel_i[SEL_W*p +: SEL_W];
    assign mode = mode_i[2*p +: 2];
    assign ana[p] = (pin_mode_e'(mode) == MODE_ANA);

    for (genvar k = 0; k < N_AF; k++) begin : g_ch
      assign ch_out[k]             = af_out_i[k*N_PINS + p];
      assign ch_oe[k]              = af_oe_i[k*N_PINS + p];
      assign af_in_o[k*N_PINS + p] = ch_in[k];
    end

    af_channel_mux #(.N_AF(N_AF), .SEL_W(SEL_W)) u_afm (
      .sel_i     (sel),
      .ch_out_i  (ch_out),
      .ch_oe_i   (ch_oe),
      .in_bit_i  (idr[p]),
      .src_out_o (src_out),
      .src_oe_o  (src_oe),
      .ch_in_o   (ch_in)
    );

    pad_ctrl_decode u_dec (
      .mode_i    (mode),
      .od_i      (otype_i[p]),
      .pull_i    (pull_i[2*p +: 2]),
      .gp_out_i  (gp_out_i[p]),
      .src_out_i (src_out),
      .src_oe_i  (src_oe),
      .ctrl_o    (ctrl)
    );

    assign pad_oe_o[p]  = ctrl.oe;
    assign pad_out_o[p] = ctrl.out;
    assign pad_pu_o[p]  = ctrl.pu;
    assign pad_pd_o[p]  = ctrl.pd;
    assign pad_ie_o[p]  = ctrl.ie;

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pad_oe_o[p] |-> !pad_out_o[p]); // R1
    AST_OD_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (otype_i[p] && (mode == 2'b01 || mode == 2'b10)) |-> !pad_out_o[p]); // R2
    AST_PULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pad_pu_o[p] && pad_pd_o[p])); // R3
    AST_ANALOG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == 2'b11) |-> !(pad_oe_o[p] || pad_ie_o[p] || pad_pu_o[p] || pad_pd_o[p])); // R4
    AST_BAD_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == 2'b10 && int'(sel) >= N_AF) |-> !pad_oe_o[p]); // R7
    AST_AF_IN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ch_in)); // R8
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (af_in_o == {AF_BITS{1'b0}})); // R11
endmodule

// File: tb/sim_pad_port_mux.sv
module sim_pad_port_mux;
  localparam int N = 16;
  localparam int NA = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*N-1:0]  mode;
  logic [N-1:0]    otype;
  logic [2*N-1:0]  pull;
  logic [4*N-1:0]  sel;
  logic [N-1:0]    gp_out;
  logic [NA*N-1:0] af_out;
  logic [NA*N-1:0] af_oe;
  logic [N-1:0]    pad_in;
  logic [N-1:0]    oe, outv, pu, pd, ie, idr;
  logic [NA*N-1:0] af_in;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pad_port_mux u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .otype_i(otype), .pull_i(pull),
    .af_sel_i(sel), .gp_out_i(gp_out), .af_out_i(af_out), .af_oe_i(af_oe),
    .pad_in_i(pad_in), .pad_oe_o(oe), .pad_out_o(outv), .pad_pu_o(pu),
    .pad_pd_o(pd), .pad_ie_o(ie), .in_data_o(idr), .af_in_o(af_in)
  );

  // requirement model of the two-edge input path (R9, R10)
  logic [N-1:0] m_s1, m_idr;
  function automatic logic [N-1:0] ana_of(logic [2*N-1:0] m);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = (m[2*p +: 2] == 2'b11);
    return r;
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_s1 <= '0; m_idr <= '0; end
    else begin m_s1 <= pad_in; m_idr <= m_s1 & ~ana_of(mode); end
  end

  // {oe,out,pu,pd,ie} for one pin
  function automatic logic [4:0] ref_pin(int p);
    logic [1:0] m = mode[2*p +: 2];
    logic [1:0] pl = pull[2*p +: 2];
    int s = int'(sel[4*p +: 4]);
    logic lvl = 1'b0, drv = 1'b0, o, e;
    if (m == 2'b01) begin lvl = gp_out[p]; drv = 1'b1; end
    if (m == 2'b10 && s < NA) begin lvl = af_out[s*N+p]; drv = af_oe[s*N+p]; end
    if (otype[p]) begin e = drv & ~lvl; o = 1'b0; end
    else begin e = drv; o = drv & lvl; end
    if (m == 2'b11) return 5'b0;
    return {e, o, pl == 2'b01, pl == 2'b10, 1'b1};
  endfunction

  task automatic chk(string tag, logic [NA*N-1:0] act, logic [NA*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [N-1:0] e_oe, e_out, e_pu, e_pd, e_ie;
    logic [NA*N-1:0] e_af;
    for (int p = 0; p < N; p++) {e_oe[p], e_out[p], e_pu[p], e_pd[p], e_ie[p]} = ref_pin(p);
    e_af = '0;
    for (int p = 0; p < N; p++)
      if (int'(sel[4*p +: 4]) < NA) e_af[int'(sel[4*p +: 4])*N + p] = m_idr[p];
    chk("R1/R2/R6/R7 pad_oe", {112'b0, oe}, {112'b0, e_oe});
    chk("R1/R2/R6/R7 pad_out", {112'b0, outv}, {112'b0, e_out});
    chk("R3/R4 pull_up", {112'b0, pu}, {112'b0, e_pu});
    chk("R3/R4 pull_dn", {112'b0, pd}, {112'b0, e_pd});
    chk("R4/R5 in_en", {112'b0, ie}, {112'b0, e_ie});
    chk("R9/R10 in_data", {112'b0, idr}, {112'b0, m_idr});
    chk("R8 af_in", af_in, e_af);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2*N-1:0] rep2(logic [1:0] v);
    return {N{v}};
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mode = '0; otype = '0; pull = '0; sel = '0; gp_out = '0;
    af_out = '0; af_oe = '0; pad_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_data after reset", {112'b0, idr}, 128'b0);
    chk("R11 af_in after reset", af_in, 128'b0);

    // R9: two-edge latency
    pad_in = 16'hA5C3;
    step();
    check_all();
    chk("R9 one edge, old value", {112'b0, idr}, {112'b0, 16'hFFFF});
    step();
    chk("R9 two edges, new value", {112'b0, idr}, {112'b0, 16'hA5C3});

    // R4/R10: analog ignores pulls and reads 0
    mode = rep2(2'b11); pull = rep2(2'b01); otype = '1;
    #1;
    chk("R4 analog pull_up off", {112'b0, pu}, 128'b0);
    chk("R4 analog in_en off", {112'b0, ie}, 128'b0);
    step();
    chk("R10 analog in_data 0", {112'b0, idr}, 128'b0);
    check_all();

    // R3: pull codes
    mode = rep2(2'b00); pull = rep2(2'b11);
    #1;
    chk("R3 reserved code no pull", {112'b0, pu | pd}, 128'b0);
    pull = rep2(2'b10);
    #1;
    chk("R3 pull-down only", {112'b0, pd & ~pu}, {112'b0, 16'hFFFF});
    chk("R5 input mode in_en", {112'b0, ie}, {112'b0, 16'hFFFF});

    // R1/R2: output types
    mode = rep2(2'b01); otype = '1; gp_out = 16'h00FF;
    #1;
    chk("R2 open-drain oe", {112'b0, oe}, {112'b0, 16'hFF00});
    chk("R2 open-drain out", {112'b0, outv}, 128'b0);
    otype = '0;
    #1;
    chk("R1 push-pull oe", {112'b0, oe}, {112'b0, 16'hFFFF});
    chk("R1 push-pull out", {112'b0, outv}, {112'b0, 16'h00FF});

    // R6/R7: channel selection
    mode = rep2(2'b10); af_oe = '1; af_out = '1; sel = {N{4'd9}};
    #1;
    chk("R7 selector 9 idle oe", {112'b0, oe}, 128'b0);
    chk("R7 selector 9 idle out", {112'b0, outv}, 128'b0);
    af_oe = '0; af_oe[3*N +: N] = 16'h0F0F; sel = {N{4'd3}};
    #1;
    chk("R6 channel 3 oe", {112'b0, oe}, {112'b0, 16'h0F0F});
    step();
    check_all();

    // random phase: mode and pad changes collide with sampling
    for (int i = 0; i < 3000; i++) begin
      mode   = {$urandom, $urandom};
      otype  = 16'($urandom);
      pull   = 32'($urandom);
      sel    = {$urandom, $urandom};
      gp_out = 16'($urandom);
      af_out = {$urandom, $urandom, $urandom, $urandom};
      af_oe  = {$urandom, $urandom, $urandom, $urandom};
      pad_in = 16'($urandom);
      step();
      check_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule